// File: doc/BRIEF.md
# GPIO Block with Host-Programmable Port Decode

This block gives a host two ways to reach twelve general-purpose pins, eight in group 1 and four in group 2. The first way is an indexed configuration register set. It holds a power-control byte, a 16-bit base address split over two bytes, and one direction byte for each group. The second way is a pair of plain I/O ports at the programmed base and at base+1. Once the base is set, firmware can drive or sample the pins with ordinary I/O reads and writes, without going through configuration mode.

All GPIO state is protected by a write-unlock bit in the power-control byte. While that bit is clear, the GPIO configuration bytes keep their values and the data ports leave the pins untouched. The same byte also produces a bus-isolate request, a refresh enable, and enable levels for two clock outputs and for the system clock.

Input pads pass through a synchronizer whose depth is set by a parameter (two stages by default) before they can be read.

Top module: `gpio_portdec`

## Requirements
- R1: After reset, the power-control byte (index 0x10) reads 0x30. The base bytes, the direction bytes and the output latches are 0x00, so all output enables are low.
- R2: The pin-control outputs follow the power-control byte from the cycle after the write. `bus_isolate` equals bit 6. `clkout1_en` is low when bit 1 is set, or when bits 6 and 5 are both set. `clkout2_en` is low when bit 2 is set, or when bits 6 and 5 are both set. `sysclk_en` is low when bits 6 and 4 are both set. `refresh_en` equals bit 3.
- R3: While bit 0 of index 0x10 is 0, configuration writes to indices 0x11 to 0x1A are ignored. Those registers still read back their stored values.
- R4: Index 0x11 holds the low byte of the base and 0x12 holds the high byte. Index 0x15 holds the group-1 direction and 0x18 holds the group-2 direction in bits 3..0, with bits 7..4 reading 0. A direction bit of 1 makes that pin an output, and `g1_oe`/`g2_oe` follow the direction bits.
- R5: An I/O write to the base address, made while bit 0 of index 0x10 is 1, loads data bits 7..0 into the group-1 output latch. `g1_out` shows the new value from the next cycle. While bit 0 is 0, the write is claimed but has no effect.
- R6: An I/O write to base+1, with writes unlocked, loads data bits 3..0 into the group-2 latch, which shows on `g2_out` from the next cycle.
- R7: An I/O read of the base returns, for each bit, the output latch when that bit is an output and the synchronized pad level when it is an input. A read of base+1 does the same for group 2 in bits 3..0, with bits 7..4 reading 0. `io_rdata` is 0 when no claimed read is active.
- R8: A pad level change becomes visible to port reads exactly SYNC_STAGES clock edges later.
- R9: Port cycles are claimed (`io_hit`) only on a full 16-bit match with the base or base+1. A base of 0x0000 disables both ports.
- R10: Indices in 0x10 to 0x1A that hold no register, and all indices outside that range, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Contents of the register at `cfg_idx` |
| io_addr | input | 16 | I/O cycle address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when not claimed |
| io_hit | output | 1 | Cycle claimed by one of the data ports |
| g1_in | input | 8 | Group-1 pad input levels |
| g1_out | output | 8 | Group-1 output latch |
| g1_oe | output | 8 | Group-1 output enables |
| g2_in | input | 4 | Group-2 pad input levels |
| g2_out | output | 4 | Group-2 output latch |
| g2_oe | output | 4 | Group-2 output enables |
| bus_isolate | output | 1 | Downstream bus isolate request |
| clkout1_en | output | 1 | Clock output 1 enable level |
| clkout2_en | output | 1 | Clock output 2 enable level |
| sysclk_en | output | 1 | System clock enable level |
| refresh_en | output | 1 | Refresh output enable |

## Verification
Configuration reads, `io_hit` and `io_rdata` are combinational, so they are due in the same cycle as the request. Register writes and latch loads appear one edge after the strobe, and pad changes reach port reads SYNC_STAGES edges after they are applied. The bench drives inputs just after the falling edge and compares every output against a behavioural model halfway through the low phase. The model advances only on rising edges. Directed checks sample at the same point, counting the edges that should have passed since the stimulus.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;
   localparam logic [7:0] IDX_PWR     = 8'h10;
   localparam logic [7:0] IDX_BASE_LO = 8'h11;
   localparam logic [7:0] IDX_BASE_HI = 8'h12;
   localparam logic [7:0] IDX_DIR1    = 8'h15;
   localparam logic [7:0] IDX_DIR2    = 8'h18;
   localparam logic [7:0] IDX_LOCK_LO = 8'h11;
   localparam logic [7:0] IDX_LOCK_HI = 8'h1A;
   localparam logic [7:0] PWR_RESET   = 8'h30;

   // Bit positions within the power-control byte
   localparam int B_UNLOCK  = 0;
   localparam int B_CK1_OFF = 1;
   localparam int B_CK2_OFF = 2;
   localparam int B_REFRESH = 3;
   localparam int B_SYS_PD  = 4;
   localparam int B_CK_PD   = 5;
   localparam int B_ISOLATE = 6;

   typedef struct packed {
      logic isolate;
      logic ck1_en;
      logic ck2_en;
      logic sys_en;
      logic refresh;
   } pwr_ctl_t;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_pd_pkg::*;
#(
   parameter int G1_W = 8,
   parameter int G2_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic [7:0]      cfg_idx,
   input  logic [7:0]      cfg_wdata,
   output logic [7:0]      cfg_rdata,
   output logic [7:0]      pwr_q,
   output logic [15:0]     base_q,
   output logic [G1_W-1:0] dir1_q,
   output logic [G2_W-1:0] dir2_q
);
   logic unlocked;
   logic in_locked_span;

   assign unlocked       = pwr_q[B_UNLOCK];
   assign in_locked_span = (cfg_idx >= IDX_LOCK_LO) && (cfg_idx <= IDX_LOCK_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_q  <= PWR_RESET;
         base_q <= '0;
         dir1_q <= '0;
         dir2_q <= '0;
      end else if (cfg_wr) begin
         if (cfg_idx == IDX_PWR)
            pwr_q <= cfg_wdata;
         else if (in_locked_span && unlocked) begin
            case (cfg_idx)
               IDX_BASE_LO: base_q[7:0]  <= cfg_wdata;
               IDX_BASE_HI: base_q[15:8] <= cfg_wdata;
               IDX_DIR1:    dir1_q       <= cfg_wdata[G1_W-1:0];
               IDX_DIR2:    dir2_q       <= cfg_wdata[G2_W-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_idx)
         IDX_PWR:     cfg_rdata = pwr_q;
         IDX_BASE_LO: cfg_rdata = base_q[7:0];
         IDX_BASE_HI: cfg_rdata = base_q[15:8];
         IDX_DIR1:    cfg_rdata[G1_W-1:0] = dir1_q;
         IDX_DIR2:    cfg_rdata[G2_W-1:0] = dir2_q;
         default:     cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_decode.sv
module gpio_port_decode #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] io_addr,
   output logic          sel_lo,
   output logic          sel_hi
);
   logic          base_on;
   logic [AW-1:0] base_nxt;

   assign base_on  = |base;
   assign base_nxt = base + AW'(1);
   assign sel_lo   = base_on && (io_addr == base);
   assign sel_hi   = base_on && (io_addr == base_nxt);
endmodule

// File: rtl/gpio_pin_group.sv
module gpio_pin_group #(
   parameter int W    = 8,
   parameter int SYNC = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         lat_we,
   input  logic [W-1:0] lat_wdata,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] rd_val
);
   logic [W-1:0] latch_q;
   logic [W-1:0] pad_s;

   always_ff @(posedge clk) begin
      if (!rst_n)      latch_q <= '0;
      else if (lat_we) latch_q <= lat_wdata;
   end

   generate
      if (SYNC == 0) begin : g_nosync
         assign pad_s = pad_in;
      end else begin : g_sync
         logic [W-1:0] stg [SYNC];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC; i++) stg[i] <= '0;
            end else begin
               stg[0] <= pad_in;
               for (int i = 1; i < SYNC; i++) stg[i] <= stg[i-1];
            end
         end
         assign pad_s = stg[SYNC-1];
      end
   endgenerate

   assign pad_out = latch_q;
   assign pad_oe  = dir;
   assign rd_val  = (dir & latch_q) | (~dir & pad_s);
endmodule

// File: rtl/gpio_portdec.sv
module gpio_portdec
   import gpio_pd_pkg::*;
#(
   parameter int G1_W        = 8,
   parameter int G2_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic [7:0]      cfg_idx,
   input  logic [7:0]      cfg_wdata,
   output logic [7:0]      cfg_rdata,
   input  logic [15:0]     io_addr,
   input  logic            io_wr,
   input  logic            io_rd,
   input  logic [7:0]      io_wdata,
   output logic [7:0]      io_rdata,
   output logic            io_hit,
   input  logic [G1_W-1:0] g1_in,
   output logic [G1_W-1:0] g1_out,
   output logic [G1_W-1:0] g1_oe,
   input  logic [G2_W-1:0] g2_in,
   output logic [G2_W-1:0] g2_out,
   output logic [G2_W-1:0] g2_oe,
   output logic            bus_isolate,
   output logic            clkout1_en,
   output logic            clkout2_en,
   output logic            sysclk_en,
   output logic            refresh_en
);
   localparam int AW = 16;

   if (G1_W < 1 || G1_W > 8) begin : g_bad_g1
      $error("G1_W must lie in 1..8");
   end
   if (G2_W < 1 || G2_W > 8) begin : g_bad_g2
      $error("G2_W must lie in 1..8");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic [7:0]      pwr_q;
   logic [AW-1:0]   base_q;
   logic [G1_W-1:0] dir1_q, rd1;
   logic [G2_W-1:0] dir2_q, rd2;
   logic            sel_lo, sel_hi, we1, we2;
   pwr_ctl_t        pc;

   gpio_cfg_regs #(.G1_W(G1_W), .G2_W(G2_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwr_q(pwr_q),
      .base_q(base_q), .dir1_q(dir1_q), .dir2_q(dir2_q)
   );

   gpio_port_decode #(.AW(AW)) u_dec (
      .base(base_q), .io_addr(io_addr), .sel_lo(sel_lo), .sel_hi(sel_hi)
   );

   assign we1 = io_wr && sel_lo && pwr_q[B_UNLOCK];
   assign we2 = io_wr && sel_hi && pwr_q[B_UNLOCK];

   gpio_pin_group #(.W(G1_W), .SYNC(SYNC_STAGES)) u_g1 (
      .clk(clk), .rst_n(rst_n), .lat_we(we1), .lat_wdata(io_wdata[G1_W-1:0]),
      .dir(dir1_q), .pad_in(g1_in), .pad_out(g1_out), .pad_oe(g1_oe), .rd_val(rd1)
   );

   gpio_pin_group #(.W(G2_W), .SYNC(SYNC_STAGES)) u_g2 (
      .clk(clk), .rst_n(rst_n), .lat_we(we2), .lat_wdata(io_wdata[G2_W-1:0]),
      .dir(dir2_q), .pad_in(g2_in), .pad_out(g2_out), .pad_oe(g2_oe), .rd_val(rd2)
   );

   assign io_hit = (io_rd || io_wr) && (sel_lo || sel_hi);

   always_comb begin
      io_rdata = '0;
      if (io_rd && sel_lo)      io_rdata[G1_W-1:0] = rd1;
      else if (io_rd && sel_hi) io_rdata[G2_W-1:0] = rd2;
   end

   always_comb begin
      pc.isolate = pwr_q[B_ISOLATE];
      pc.ck1_en  = !pwr_q[B_CK1_OFF] && !(pwr_q[B_ISOLATE] && pwr_q[B_CK_PD]);
      pc.ck2_en  = !pwr_q[B_CK2_OFF] && !(pwr_q[B_ISOLATE] && pwr_q[B_CK_PD]);
      pc.sys_en  = !(pwr_q[B_ISOLATE] && pwr_q[B_SYS_PD]);
      pc.refresh = pwr_q[B_REFRESH];
   end

   assign bus_isolate = pc.isolate;
   assign clkout1_en  = pc.ck1_en;
   assign clkout2_en  = pc.ck2_en;
   assign sysclk_en   = pc.sys_en;
   assign refresh_en  = pc.refresh;
endmodule

// File: rtl/gpio_portdec_chk.sv
module gpio_portdec_chk #(
   parameter int G1_W = 8,
   parameter int G2_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_wr,
   input logic [7:0]      cfg_idx,
   input logic [15:0]     io_addr,
   input logic            io_wr,
   input logic            io_rd,
   input logic [7:0]      io_wdata,
   input logic [7:0]      io_rdata,
   input logic            io_hit,
   input logic [G1_W-1:0] g1_out,
   input logic [G1_W-1:0] g1_oe,
   input logic [G2_W-1:0] g2_out,
   input logic [G2_W-1:0] g2_oe,
   input logic            bus_isolate,
   input logic [7:0]      pwr_q,
   input logic [15:0]     base_q
);
   // R3
   locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !pwr_q[0] && cfg_idx != 8'h10)
      |=> ($stable(g1_oe) && $stable(g2_oe) && $stable(base_q)));

   // R5
   port_drive_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && pwr_q[0] && base_q != 16'h0 && io_addr == base_q)
      |=> (g1_out == $past(io_wdata[G1_W-1:0])));

   // R6
   port_drive_g2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && pwr_q[0] && base_q != 16'h0 && io_addr == base_q + 16'd1)
      |=> (g2_out == $past(io_wdata[G2_W-1:0])));

   // R9
   zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q == 16'h0) |-> !io_hit);

   // R7
   quiet_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_hit) |-> (io_rdata == 8'h00));

   // R2
   isolate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_isolate) |-> $past(cfg_wr && cfg_idx == 8'h10));
endmodule

bind gpio_portdec gpio_portdec_chk #(.G1_W(G1_W), .G2_W(G2_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
   .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
   .io_rdata(io_rdata), .io_hit(io_hit), .g1_out(g1_out), .g1_oe(g1_oe),
   .g2_out(g2_out), .g2_oe(g2_oe), .bus_isolate(bus_isolate),
   .pwr_q(pwr_q), .base_q(base_q)
);

// File: tb/gpio_portdec_test.sv
module gpio_portdec_test;
   localparam int SYNC = 2;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_wr = 0;
   logic [7:0]  cfg_idx = 8'h10;
   logic [7:0]  cfg_wdata = 0;
   logic [7:0]  cfg_rdata;
   logic [15:0] io_addr = 0;
   logic        io_wr = 0, io_rd = 0;
   logic [7:0]  io_wdata = 0;
   logic [7:0]  io_rdata;
   logic        io_hit;
   logic [7:0]  g1_in = 0, g1_out, g1_oe;
   logic [3:0]  g2_in = 0, g2_out, g2_oe;
   logic        bus_isolate, clkout1_en, clkout2_en, sysclk_en, refresh_en;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_portdec #(.G1_W(8), .G2_W(4), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .io_hit(io_hit), .g1_in(g1_in), .g1_out(g1_out), .g1_oe(g1_oe),
      .g2_in(g2_in), .g2_out(g2_out), .g2_oe(g2_oe), .bus_isolate(bus_isolate),
      .clkout1_en(clkout1_en), .clkout2_en(clkout2_en), .sysclk_en(sysclk_en),
      .refresh_en(refresh_en)
   );

   // Behavioural reference state
   logic [7:0] m_pwr, m_blo, m_bhi, m_dir1, m_lat1;
   logic [3:0] m_dir2, m_lat2;
   logic [7:0] q1[$];
   logic [3:0] q2[$];

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      logic        en;
      logic [15:0] base;
      if (!rst_n) begin
         m_pwr = 8'h30; m_blo = 0; m_bhi = 0; m_dir1 = 0; m_dir2 = 0;
         m_lat1 = 0; m_lat2 = 0;
         q1.delete(); q2.delete();
         for (int i = 0; i < SYNC; i++) begin q1.push_back(0); q2.push_back(0); end
      end else begin
         en   = m_pwr[0];
         base = {m_bhi, m_blo};
         if (io_wr && en && base != 0) begin
            if (io_addr == base) m_lat1 = io_wdata;
            else if (io_addr == base + 16'd1) m_lat2 = io_wdata[3:0];
         end
         if (cfg_wr) begin
            if (cfg_idx == 8'h10) m_pwr = cfg_wdata;
            else if (en) begin
               case (cfg_idx)
                  8'h11: m_blo = cfg_wdata;
                  8'h12: m_bhi = cfg_wdata;
                  8'h15: m_dir1 = cfg_wdata;
                  8'h18: m_dir2 = cfg_wdata[3:0];
                  default: ;
               endcase
            end
         end
         q1.push_front(g1_in); void'(q1.pop_back());
         q2.push_front(g2_in); void'(q2.pop_back());
      end
   end

   // Per-cycle comparison in the low phase
   always @(negedge clk) begin
      logic [15:0] base, bp1;
      logic        hlo, hhi;
      logic [7:0]  erd, ecfg;
      #5;
      if (rst_n && !done) begin
         base = {m_bhi, m_blo};
         bp1  = base + 16'd1;
         hlo  = (base != 0) && (io_addr == base);
         hhi  = (base != 0) && (io_addr == bp1);
         erd  = 8'h00;
         if (io_rd && hlo)      erd = (m_dir1 & m_lat1) | (~m_dir1 & q1[SYNC-1]);
         else if (io_rd && hhi) erd = {4'h0, (m_dir2 & m_lat2) | (~m_dir2 & q2[SYNC-1])};
         case (cfg_idx)
            8'h10: ecfg = m_pwr;
            8'h11: ecfg = m_blo;
            8'h12: ecfg = m_bhi;
            8'h15: ecfg = m_dir1;
            8'h18: ecfg = {4'h0, m_dir2};
            default: ecfg = 8'h00;
         endcase
         chk("R3/R10 cfg_rdata", 16'(cfg_rdata), 16'(ecfg));
         chk("R9 io_hit", 16'(io_hit), 16'((io_rd || io_wr) && (hlo || hhi)));
         chk("R7 io_rdata", 16'(io_rdata), 16'(erd));
         chk("R4 oe", {4'h0, g2_oe, g1_oe}, {4'h0, m_dir2, m_dir1});
         chk("R5 g1_out", 16'(g1_out), 16'(m_lat1));
         chk("R6 g2_out", 16'(g2_out), 16'(m_lat2));
         chk("R2 pwr outs", {11'h0, bus_isolate, clkout1_en, clkout2_en, sysclk_en, refresh_en},
             {11'h0, m_pwr[6], !m_pwr[1] && !(m_pwr[6] && m_pwr[5]),
              !m_pwr[2] && !(m_pwr[6] && m_pwr[5]), !(m_pwr[6] && m_pwr[4]), m_pwr[3]});
      end
   end

   task automatic cfg_put(logic [7:0] idx, logic [7:0] d);
      @(negedge clk); #1;
      cfg_idx = idx; cfg_wdata = d; cfg_wr = 1;
      @(negedge clk); #1;
      cfg_wr = 0;
   endtask

   task automatic io_put(logic [15:0] a, logic [7:0] d);
      @(negedge clk); #1;
      io_addr = a; io_wdata = d; io_wr = 1;
      @(negedge clk); #1;
      io_wr = 0;
   endtask

   task automatic probe; #4; endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      probe();
      // R1 reset state
      chk("R1 pwr byte", 16'(cfg_rdata), 16'h30);
      chk("R1 oe", {4'h0, g2_oe, g1_oe}, 16'h0);
      chk("R1 latches", {4'h0, g2_out, g1_out}, 16'h0);

      // R3 locked write
      cfg_put(8'h11, 8'h50);
      cfg_idx = 8'h11; probe();
      chk("R3 locked base lo", 16'(cfg_rdata), 16'h00);

      // R4 unlock, program base and directions
      cfg_put(8'h10, 8'h31);
      cfg_put(8'h11, 8'h50);
      cfg_put(8'h12, 8'h01);
      cfg_put(8'h15, 8'hF0);
      cfg_put(8'h18, 8'hFF);
      probe();
      chk("R4 dir2 upper zero", 16'(cfg_rdata), 16'h0F);
      cfg_idx = 8'h12; #1;
      chk("R4 base hi", 16'(cfg_rdata), 16'h01);
      chk("R4 g1_oe", 16'(g1_oe), 16'hF0);

      // R5, R6 port writes
      io_put(16'h0150, 8'hAA);
      probe();
      chk("R5 g1_out", 16'(g1_out), 16'hAA);
      io_put(16'h0151, 8'h55);
      probe();
      chk("R6 g2_out", 16'(g2_out), 16'h5);

      // R7 mixed read
      @(negedge clk); #1 g1_in = 8'h3C;
      repeat (3) @(negedge clk);
      #1 io_addr = 16'h0150; io_rd = 1; probe();
      chk("R7 g1 mixed read", 16'(io_rdata), 16'hAC);
      @(negedge clk); #1 io_addr = 16'h0151; probe();
      chk("R7 g2 read upper zero", 16'(io_rdata), 16'h05);
      @(negedge clk); #1 io_rd = 0;

      // R8 synchronizer latency
      cfg_put(8'h15, 8'h00);
      io_addr = 16'h0150; io_rd = 1; g1_in = 8'h81; probe();
      chk("R8 edge 0", 16'(io_rdata), 16'h3C);
      @(negedge clk); #5;
      chk("R8 edge 1", 16'(io_rdata), 16'h3C);
      @(negedge clk); #5;
      chk("R8 edge 2", 16'(io_rdata), 16'h81);
      @(negedge clk); #1 io_rd = 0;

      // R5 port write while locked
      cfg_put(8'h10, 8'h30);
      @(negedge clk); #1 io_addr = 16'h0150; io_wdata = 8'h11; io_wr = 1; probe();
      chk("R5 locked claim", 16'(io_hit), 16'h1);
      @(negedge clk); #1 io_wr = 0; probe();
      chk("R5 locked no effect", 16'(g1_out), 16'hAA);
      cfg_put(8'h10, 8'h31);

      // R9 full match and zero base
      io_put(16'h0250, 8'h33);
      probe();
      chk("R9 upper byte mismatch", 16'(g1_out), 16'hAA);
      cfg_put(8'h11, 8'h00);
      cfg_put(8'h12, 8'h00);
      @(negedge clk); #1 io_addr = 16'h0000; io_wdata = 8'h77; io_wr = 1; probe();
      chk("R9 zero base no claim", 16'(io_hit), 16'h0);
      @(negedge clk); #1 io_wr = 0; probe();
      chk("R9 zero base no write", 16'(g1_out), 16'hAA);

      // R2 power-control outputs
      cfg_put(8'h10, 8'h71);
      probe();
      chk("R2 isolate set", {11'h0, bus_isolate, clkout1_en, clkout2_en, sysclk_en, refresh_en}, 16'h10);
      cfg_put(8'h10, 8'h0D);
      probe();
      chk("R2 refresh and ck2 off", {11'h0, bus_isolate, clkout1_en, clkout2_en, sysclk_en, refresh_en}, 16'h0B);

      // R10 holes and out-of-range indices
      cfg_put(8'h20, 8'hFF);
      cfg_idx = 8'h20; probe();
      chk("R10 out of range", 16'(cfg_rdata), 16'h00);
      cfg_put(8'h13, 8'hFF);
      cfg_idx = 8'h13; probe();
      chk("R10 hole index", 16'(cfg_rdata), 16'h00);
      cfg_idx = 8'h10; #1;
      chk("R10 pwr untouched", 16'(cfg_rdata), 16'h0D);

      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule